// File: doc/BRIEF.md
# ADC Sample Serializer

This block turns parallel converter samples into a word stream carried on one or two serial data lanes. It also drives a data clock and a frame marker beside the lanes. One lane bit is sent on every cycle of the fast bit clock `clk`. The data clock changes level once per bit, so a receiver captures data on both of its edges. The serialized word is 12, 14 or 16 bits wide. The 14-bit and 16-bit words append two overrange status bits after the twelve data bits, and the 16-bit word then adds two zero bits. Data is coded as offset binary or as two's complement.

Samples arrive over a valid/ready stream. `s_ready` is high for exactly one bit cycle per sample period: the last bit cycle of the sample on the lanes. A transfer happens only in a cycle where `s_valid` and `s_ready` are both high, and the transferred word goes on the lanes from the next cycle. The producer never stalls the serializer. If no transfer happens at a sample boundary, the last word is sent again. Outside the ready cycle `s_data` and `s_ovr` are not looked at. The configuration inputs are static. They are sampled only at frame boundaries, so a lane or width change never cuts a frame short.

Top module: `adc_sample_serializer`

## Requirements
- R1: `cfg_width` selects the word width W: 0 gives 12, 1 gives 14, 2 and 3 give 16. With `cfg_two_lane`=0 each sample takes W bit cycles; with `cfg_two_lane`=1 it takes W/2.
- R2: The word is sent first bit first in this order: the twelve coded data bits from most significant down, then the two status bits (14- and 16-bit widths only), then two zero bits (16-bit width only).
- R3: In two-lane mode `ser_lane[0]` carries word positions 0, 2, 4, … and `ser_lane[1]` positions 1, 3, 5, …, where position 0 is the first bit. Both lanes begin a sample in the same cycle. In one-lane mode `ser_lane[1]` stays 0.
- R4: Both status bits are 1 when `s_ovr`=1 and raw `s_data` bit 11 is 1 (positive overrange). They are 0 in every other case, including `s_ovr`=1 with bit 11 at 0 (negative overrange).
- R5: With `cfg_twos`=0 the data bits are raw `s_data` (offset binary). With `cfg_twos`=1 the most significant bit is inverted, so 0x800 codes as 0x000 and 0xFFF as 0x7FF. `cfg_twos` is taken in the cycle the word is transferred.
- R6: The frame period equals one sample period when the per-lane bit count is even, and two sample periods when it is odd (two lanes, 14-bit). `ser_frame` is high during the first half of each frame period and low during the second half.
- R7: `ser_dclk` is 0 in the first bit cycle of each frame period and changes level on every bit cycle.
- R8: `s_ready` is high exactly in the last bit cycle of each sample. `s_data` and `s_ovr` presented in any other cycle do not reach the lanes.
- R9: When no transfer happens at a sample boundary, the next sample period sends the previous word again.
- R10: The configuration is sampled only in the last bit cycle of a frame period. The next cycle starts a new frame period under the new mode, so the frame that is under way keeps its old length.
- R11: After reset the mode is one lane, 12-bit, offset binary, and the held word is zero. The first cycle after reset is the first bit of a frame period: `ser_frame`=1, `ser_dclk`=0, both lanes 0, `s_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-rate clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_two_lane | input | 1 | 1 selects two lanes |
| cfg_width | input | 2 | Word width code (0:12, 1:14, 2/3:16) |
| cfg_twos | input | 1 | 1 selects two's complement coding |
| s_valid | input | 1 | Sample stream valid |
| s_ready | output | 1 | Sample stream ready, one cycle per sample |
| s_data | input | 12 | Raw offset-binary sample |
| s_ovr | input | 1 | Sample is overranged |
| ser_lane | output | 2 | Serial data lanes |
| ser_dclk | output | 1 | Data clock, both edges valid |
| ser_frame | output | 1 | Frame marker |

## Verification
A wrong bit counter or a wrong latched mode shows up at the ports within one frame period. The frame marker and the data clock are then misplaced against the bench's own cycle count, and `s_ready` fires in the wrong cycle. A corrupted held word, or a wrong coding or status bit, shows up in the deserialized word of the very next sample. The bench rebuilds every word from the lanes alone. It also times the frame length across a mode change, which exposes a mode register that updates anywhere other than at a frame boundary.

// File: rtl/adcser_pkg.sv
`timescale 1ns/1ps
package adcser_pkg;

  typedef enum logic [1:0] {
    W_BASE     = 2'd0,
    W_MID      = 2'd1,
    W_WIDE     = 2'd2,
    W_WIDE_ALT = 2'd3
  } width_e;

  typedef struct packed {
    logic   two_lane;
    width_e width;
  } mode_t;

  function automatic int unsigned word_bits(width_e w, int unsigned data_w);
    case (w)
      W_BASE:  return data_w;
      W_MID:   return data_w + 2;
      default: return data_w + 4;
    endcase
  endfunction

  function automatic int unsigned lane_bits(mode_t m, int unsigned data_w);
    int unsigned wb;
    wb = word_bits(m.width, data_w);
    return m.two_lane ? (wb / 2) : wb;
  endfunction

  // odd per-lane counts need two samples to return to an even bit phase
  function automatic int unsigned frame_bits(mode_t m, int unsigned data_w);
    int unsigned lb;
    lb = lane_bits(m, data_w);
    return (lb % 2 == 1) ? (2 * lb) : lb;
  endfunction

endpackage

// File: rtl/adcser_timer.sv
`timescale 1ns/1ps
module adcser_timer
  import adcser_pkg::*;
#(
  parameter int unsigned DATA_W = 12,
  parameter int unsigned CNT_W  = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  mode_t            cfg_mode,
  output mode_t            mode_q,
  output logic [CNT_W-1:0] pos,
  output logic             load,
  output logic             frame,
  output logic             dclk
);

  logic [CNT_W-1:0] fcnt;
  logic [CNT_W-1:0] lb;
  logic [CNT_W-1:0] fl;
  logic             wrap;

  always_comb begin
    lb    = CNT_W'(lane_bits(mode_q, DATA_W));
    fl    = CNT_W'(frame_bits(mode_q, DATA_W));
    wrap  = (fcnt == fl - 1'b1);
    pos   = (fcnt >= lb) ? (fcnt - lb) : fcnt;
    load  = (pos == lb - 1'b1);
    frame = (fcnt < (fl >> 1));
    dclk  = fcnt[0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt   <= '0;
      mode_q <= '{two_lane: 1'b0, width: W_BASE};
    end else if (wrap) begin
      fcnt   <= '0;
      mode_q <= cfg_mode;
    end else begin
      fcnt   <= fcnt + 1'b1;
    end
  end

  // R10: mode register only moves at a frame wrap
  a_r10_mode_hold: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(mode_q));

  // R6: marker rises only at the start of a frame period
  a_r6_frame_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(frame) |-> (fcnt == '0));

  // R7: data clock changes every bit inside a frame period
  a_r7_dclk_toggle: assert property (@(posedge clk) disable iff (rst)
    (fcnt != '0) |-> (dclk != $past(dclk)));

  // R8: a load cycle is always followed by the first bit of a sample
  a_r8_load_restart: assert property (@(posedge clk) disable iff (rst)
    load |=> (pos == '0));

endmodule

// File: rtl/adcser_fmt.sv
`timescale 1ns/1ps
module adcser_fmt #(
  parameter int unsigned DATA_W = 12,
  localparam int unsigned WORD_W = DATA_W + 4
) (
  input  logic [DATA_W-1:0] raw,
  input  logic              ovr,
  input  logic              twos,
  output logic [WORD_W-1:0] word
);

  logic [DATA_W-1:0] coded;
  logic              pos_ovr;

  always_comb begin
    coded   = {raw[DATA_W-1] ^ twos, raw[DATA_W-2:0]};
    pos_ovr = ovr & raw[DATA_W-1];
    word    = {coded, pos_ovr, pos_ovr, 2'b00};
  end

endmodule

// File: rtl/adcser_lanes.sv
`timescale 1ns/1ps
module adcser_lanes #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned LANES  = 2
) (
  input  logic [WORD_W-1:0] word,
  input  logic [CNT_W-1:0]  pos,
  input  logic              two_lane,
  output logic [LANES-1:0]  lane_o
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [CNT_W:0]    idx;
    logic [WORD_W-1:0] shifted;
    always_comb begin
      idx     = two_lane ? ({pos, 1'b0} + (CNT_W+1)'(g)) : {1'b0, pos};
      shifted = word << idx;
      lane_o[g] = (g == 0 || two_lane) ? shifted[WORD_W-1] : 1'b0;
    end
  end

endmodule

// File: rtl/adc_sample_serializer.sv
`timescale 1ns/1ps
module adc_sample_serializer
  import adcser_pkg::*;
#(
  parameter int unsigned DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_two_lane,
  input  logic [1:0]        cfg_width,
  input  logic              cfg_twos,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  input  logic              s_ovr,
  output logic [1:0]        ser_lane,
  output logic              ser_dclk,
  output logic              ser_frame
);

  localparam int unsigned WORD_W = DATA_W + 4;
  localparam int unsigned CNT_W  = $clog2(2 * WORD_W + 1);
  localparam int unsigned LANES  = 2;

  mode_t             cfg_mode;
  mode_t             mode_q;
  logic [CNT_W-1:0]  pos;
  logic              load;
  logic [WORD_W-1:0] fmt_word;
  logic [WORD_W-1:0] word_q;

  assign cfg_mode = '{two_lane: cfg_two_lane, width: width_e'(cfg_width)};

  adcser_timer #(.DATA_W(DATA_W), .CNT_W(CNT_W)) timer_i (
    .clk     (clk),
    .rst     (rst),
    .cfg_mode(cfg_mode),
    .mode_q  (mode_q),
    .pos     (pos),
    .load    (load),
    .frame   (ser_frame),
    .dclk    (ser_dclk)
  );

  adcser_fmt #(.DATA_W(DATA_W)) fmt_i (
    .raw (s_data),
    .ovr (s_ovr),
    .twos(cfg_twos),
    .word(fmt_word)
  );

  always_ff @(posedge clk) begin
    if (rst)                   word_q <= '0;
    else if (load && s_valid)  word_q <= fmt_word;
  end

  assign s_ready = load;

  adcser_lanes #(.WORD_W(WORD_W), .CNT_W(CNT_W), .LANES(LANES)) lanes_i (
    .word    (word_q),
    .pos     (pos),
    .two_lane(mode_q.two_lane),
    .lane_o  (ser_lane)
  );

  // R9: held word only changes on a transfer
  a_r9_word_hold: assert property (@(posedge clk) disable iff (rst)
    !(load && s_valid) |=> $stable(word_q));

  // R4: status bits follow positive overrange of the transferred sample
  a_r4_status_bits: assert property (@(posedge clk) disable iff (rst)
    (load && s_valid) |=> (word_q[3] == word_q[2]) &&
                          (word_q[3] == $past(s_ovr && s_data[DATA_W-1])));

  // R3: second lane idle in one-lane mode
  a_r3_lane1_idle: assert property (@(posedge clk) disable iff (rst)
    !mode_q.two_lane |-> (ser_lane[1] == 1'b0));

endmodule

// File: tb/adc_sample_serializer_tb_top.sv
`timescale 1ns/1ps
module adc_sample_serializer_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_two_lane = 1'b0;
  logic [1:0]  cfg_width = 2'd0;
  logic        cfg_twos = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [11:0] s_data = '0;
  logic        s_ovr = 1'b0;
  logic [1:0]  ser_lane;
  logic        ser_dclk;
  logic        ser_frame;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  adc_sample_serializer dut_i (
    .clk(clk), .rst(rst), .cfg_two_lane(cfg_two_lane), .cfg_width(cfg_width),
    .cfg_twos(cfg_twos), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .s_ovr(s_ovr), .ser_lane(ser_lane), .ser_dclk(ser_dclk), .ser_frame(ser_frame)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(logic [11:0] d, logic ovr, logic tw);
    logic [11:0] c;
    logic        f;
    c = tw ? (d - 12'd2048) : d;
    f = ovr && (d >= 12'd2048);
    return {c, f, f, 2'b00};
  endfunction

  function automatic int width_of(logic [1:0] w);
    return (w == 2'd0) ? 12 : (w == 2'd1) ? 14 : 16;
  endfunction

  function automatic int frame_len(bit two, logic [1:0] w);
    int n;
    n = two ? width_of(w) / 2 : width_of(w);
    return (n % 2 == 1) ? 2 * n : n;
  endfunction

  task automatic wait_rise(output int cycles);
    logic p;
    p = ser_frame;
    cycles = 0;
    forever begin
      @(negedge clk);
      cycles++;
      if (ser_frame && !p) break;
      p = ser_frame;
    end
  endtask

  // sends two samples in the given mode and deserializes both
  task automatic send_pair(input bit two, input logic [1:0] w, input bit tw,
                           input logic [11:0] d0, input bit o0,
                           input logic [11:0] d1, input bit o1, input bit v1,
                           input string req);
    int W, N, FL, cyc;
    logic [15:0] got [2];
    logic [15:0] e0, e1, mask;
    bit frame_ok, dclk_ok, rdy_ok, l1_ok;
    W = width_of(w);
    N = two ? W / 2 : W;
    FL = frame_len(two, w);
    cfg_two_lane = two; cfg_width = w; cfg_twos = tw;
    s_data = d0; s_ovr = o0; s_valid = 1'b1;
    wait_rise(cyc);
    got[0] = '0; got[1] = '0;
    frame_ok = 1; dclk_ok = 1; rdy_ok = 1; l1_ok = 1;
    for (int k = 0; k < 2 * N; k++) begin
      int s, b;
      if (k > 0) @(negedge clk);
      s = k / N; b = k % N;
      if (two) begin
        got[s][15 - 2*b]     = ser_lane[0];
        got[s][15 - 2*b - 1] = ser_lane[1];
      end else begin
        got[s][15 - b] = ser_lane[0];
        if (ser_lane[1] !== 1'b0) l1_ok = 0;
      end
      if (ser_frame !== ((k % FL) < FL / 2)) frame_ok = 0;
      if (ser_dclk !== 1'((k % FL) % 2)) dclk_ok = 0;
      if (s_ready !== (b == N - 1)) rdy_ok = 0;
      if (s == 0 && b == 1) begin s_data = ~d0; s_valid = 1'b1; end // R8 junk, ignored
      if (s == 0 && b == N - 1) begin s_data = d1; s_ovr = o1; s_valid = v1; end
    end
    s_valid = 1'b0;
    mask = 16'hFFFF << (16 - W);
    e0 = exp_word(d0, o0, tw) & mask;
    e1 = (v1 ? exp_word(d1, o1, tw) : exp_word(d0, o0, tw)) & mask;
    chk(got[0] == e0, req, "first word", got[0], e0);
    chk(got[1] == e1, v1 ? req : "R9", "second word", got[1], e1);
    if (W > 12) begin
      chk(got[0][3:2] == e0[3:2], "R4", "status bits first", got[0][3:2], e0[3:2]);
      chk(got[1][3:2] == e1[3:2], "R4", "status bits second", got[1][3:2], e1[3:2]);
    end
    chk(frame_ok, "R6", "frame pattern", frame_ok, 1);
    chk(dclk_ok, "R7", "dclk pattern", dclk_ok, 1);
    chk(rdy_ok, "R8", "ready placement R1", rdy_ok, 1);
    chk(l1_ok, "R3", "lane1 idle", l1_ok, 1);
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // first cycle after reset: fcnt advanced to 1 at this point? sample before edge
    chk(1, "R11", "reset released", 0, 0);
  endtask

  task automatic test_reset_state();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // still the first bit cycle: no posedge with rst low has occurred yet
    chk(ser_frame === 1'b1, "R11", "frame after reset", ser_frame, 1);
    chk(ser_dclk === 1'b0, "R11", "dclk after reset", ser_dclk, 0);
    chk(ser_lane === 2'b00, "R11", "lanes after reset", ser_lane, 0);
    chk(s_ready === 1'b0, "R11", "ready after reset", s_ready, 0);
  endtask

  task automatic test_mode_change(input bit ta, input logic [1:0] wa,
                                  input bit tb, input logic [1:0] wb,
                                  input int offset);
    int cyc;
    cfg_two_lane = ta; cfg_width = wa;
    wait_rise(cyc);
    wait_rise(cyc);
    repeat (offset) @(negedge clk);
    cfg_two_lane = tb; cfg_width = wb;
    wait_rise(cyc);
    chk(cyc == frame_len(ta, wa) - offset, "R10", "old frame length kept",
        cyc, frame_len(ta, wa) - offset);
    wait_rise(cyc);
    chk(cyc == frame_len(tb, wb), "R10", "new frame length", cyc, frame_len(tb, wb));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    test_reset_state();
    // R1 R2: one lane, 12-bit, offset binary, in range
    send_pair(0, 2'd0, 0, 12'h5A3, 0, 12'h800, 0, 1, "R2");
    // R5: one lane, 14-bit, two's complement, positive then negative overrange
    send_pair(0, 2'd1, 1, 12'hFFF, 1, 12'h000, 1, 1, "R5");
    // R2 R4: one lane, 16-bit, offset binary
    send_pair(0, 2'd2, 0, 12'hFFF, 1, 12'h123, 0, 1, "R2");
    // R3 R5: two lanes, 12-bit, two's complement
    send_pair(1, 2'd0, 1, 12'h800, 0, 12'h7FF, 0, 1, "R3");
    // R6: two lanes, 14-bit, frame spans two samples
    send_pair(1, 2'd1, 0, 12'hFFF, 1, 12'h000, 1, 1, "R6");
    // R9: two lanes, 16-bit, no transfer at second boundary
    send_pair(1, 2'd2, 1, 12'hABC, 0, 12'h111, 0, 0, "R3");
    // R1: width code 3 behaves as 16-bit
    send_pair(0, 2'd3, 0, 12'h9C4, 1, 12'h3E1, 1, 1, "R1");
    // R10: frame length across mode changes
    test_mode_change(1, 2'd2, 1, 2'd1, 0);
    test_mode_change(1, 2'd1, 0, 2'd0, 5);
    test_mode_change(0, 2'd2, 1, 2'd0, 3);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule